// File: doc/BRIEF.md
# NAND bus cycle timing generator

This block turns single transfer requests into strobe waveforms for an asynchronous NAND flash bus that is 8 or 16 bits wide. A request names a command, an address, a write data word or a read data word. The block then lowers chip enable. It raises the command or address latch when the transfer needs one. It pulses write-enable or read-enable for a programmed number of system clock cycles. Read data is captured on the last cycle of the read-enable low phase. Every duration comes from one packed 26-bit timing word. Each strobe's low and high lengths are worked out from a pair of offsets within that word. The same word also holds a turnaround gap after reads, a busy sampling delay after commands that make the flash busy, and an extra chip-enable access delay before the first read.

The timing word and a configuration bit (bus width) are write-protected. A 16-bit key must be written to the lock register first. Each key write arms exactly one protected write. Software, or a page sequencer above this block, issues one request at a time while `idle_o` is high and waits for the `done_o` pulse. It reads `ready_o` to learn when the device has finished an internal operation.

Top module: `nand_strobe_gen`

## Requirements
- R1: Register select 0 is the lock, 1 is the timing word and 2 is the configuration (bit 0 = 16-bit bus). A write to select 1 or 2 is ignored unless the value 0xA25E was last written to select 0 with no protected write since. The timing word packs the fields write-low [3:0], write-high [7:4], read-low [11:8], read-high [15:12], turnaround [18:16], busy delay [23:19] and CE access delay [25:24]. After reset the timing word is all ones and the bus is 8 bits wide.
- R2: The first protected write after a correct key relocks the registers. A lock write with any other value also leaves them locked.
- R3: For command, address and write data transfers (kind codes 0, 1, 2), write-enable is low for write-low+1 cycles. It is then high for write-high minus write-low cycles, or 1 cycle when that difference is not positive. No turnaround follows.
- R4: For read transfers (kind code 3), read-enable is low for read-low+1 cycles and then high for read-high minus read-low cycles (minimum 1). The data bus is captured on the last low cycle. In 8-bit mode only the low byte is kept and the upper byte reads zero.
- R5: After the read high phase, chip enable stays low with no strobe for turnaround cycles before the transfer ends.
- R6: A read requested with the first-access flag holds chip enable low for CE-access-delay cycles before read-enable falls. Without the flag, or with a zero delay, no cycles are inserted.
- R7: A request is accepted only while `idle_o` is high. A request made during a transfer is dropped and starts nothing.
- R8: `done_o` is high for exactly one cycle: the first cycle after the last cycle with chip enable low.
- R9: When a transfer marked as making the device busy completes, `ready_o` is held low for busy-delay cycles, starting with the `done_o` cycle.
- R10: Outside such a window, `ready_o` follows the ready/busy pin through two synchronizer flops, so a pin change shows on the second clock edge.
- R11: The command latch is high during command transfers and the address latch during address transfers. The data bus is driven during the strobe phases of non-read transfers, with the upper byte zero in 8-bit mode. Write-enable and read-enable are never low together, and only while chip enable is low.
- R12: The timing word and bus width are latched when a request is accepted. Register writes during a transfer affect only later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 lock, 1 timing, 2 configuration |
| reg_wdata | input | 26 | Register write data |
| timing_o | output | 26 | Current timing word |
| bus16_o | output | 1 | Current bus width setting, 1 = 16 bits |
| unlocked_o | output | 1 | A valid key is armed |
| req_i | input | 1 | Transfer request |
| req_kind_i | input | 2 | 0 command, 1 address, 2 write data, 3 read data |
| req_data_i | input | 16 | Byte or word to drive on writes |
| req_busy_i | input | 1 | Transfer makes the device busy |
| req_first_i | input | 1 | First read after chip enable asserts |
| idle_o | output | 1 | Ready to accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Last captured read data |
| ready_o | output | 1 | Device ready, qualified by busy delay |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write-enable strobe, active low |
| nand_re_n | output | 1 | Read-enable strobe, active low |
| nand_dq_o | output | 16 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 16 | Data bus input value |
| nand_rb_i | input | 1 | Ready/busy pin, low while busy |

## Verification
The assertions check several rules on every cycle. A protected write consumes the unlock, and a locked write leaves the timing word unchanged. Each strobe low phase ends after exactly the programmed count. The completion pulse lasts one cycle, and leaving idle always follows a request. The strobes stay mutually exclusive inside chip enable, and the busy window forces ready low. Only the bench scenarios can show the absolute lengths of the high, turnaround and CE-access phases at the extremes of each field, the byte masking of captured read data, the two-edge synchronizer latency, and that a timing change made mid-transfer waits for the next request.

// File: rtl/nand_tg_pkg.sv
package nand_tg_pkg;

  localparam int unsigned PH_W   = 4;
  localparam int unsigned LEN_W  = PH_W + 1;
  localparam int unsigned BUSY_W = 5;
  localparam int unsigned DQ_W   = 16;

  typedef enum logic [1:0] {
    XF_CMD   = 2'd0,
    XF_ADDR  = 2'd1,
    XF_WDATA = 2'd2,
    XF_RDATA = 2'd3
  } xfer_kind_t;

  typedef enum logic [1:0] {
    RSEL_LOCK   = 2'd0,
    RSEL_TIMING = 2'd1,
    RSEL_CONFIG = 2'd2
  } reg_sel_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CEA,
    ST_LOW,
    ST_HIGH,
    ST_TURN
  } seq_state_t;

  typedef struct packed {
    logic [1:0]        cea;
    logic [BUSY_W-1:0] busy;
    logic [2:0]        turn;
    logic [PH_W-1:0]   rd_hi;
    logic [PH_W-1:0]   rd_lo;
    logic [PH_W-1:0]   wr_hi;
    logic [PH_W-1:0]   wr_lo;
  } timing_t;

  localparam int unsigned TIMING_W = $bits(timing_t);

  function automatic logic [LEN_W-1:0] low_len(input logic [PH_W-1:0] lo);
    return LEN_W'(lo) + LEN_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] high_len(input logic [PH_W-1:0] hi,
                                                input logic [PH_W-1:0] lo);
    if (hi > lo) return LEN_W'(hi - lo);
    return LEN_W'(1);
  endfunction

endpackage

// File: rtl/nand_tg_regs.sv
module nand_tg_regs
  import nand_tg_pkg::*;
#(
  parameter logic [15:0] UNLOCK_KEY = 16'hA25E
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_sel,
  input  logic [TIMING_W-1:0] reg_wdata,
  output timing_t             timing_o,
  output logic                bus16_o,
  output logic                unlocked_o
);

  localparam int unsigned KEY_W = $bits(UNLOCK_KEY);

  timing_t timing_q, timing_d;
  logic    bus16_q, bus16_d;
  logic    unlocked_q, unlocked_d;
  logic    wr_lock, wr_prot, key_ok;
  logic    lock_en, timing_en, cfg_en;

  always_comb begin
    wr_lock   = reg_wr && (reg_sel == RSEL_LOCK);
    wr_prot   = reg_wr && unlocked_q &&
                ((reg_sel == RSEL_TIMING) || (reg_sel == RSEL_CONFIG));
    key_ok    = (reg_wdata[KEY_W-1:0] == UNLOCK_KEY);
    lock_en   = wr_lock || wr_prot;
    unlocked_d = wr_lock && key_ok;
    timing_en = wr_prot && (reg_sel == RSEL_TIMING);
    timing_d  = timing_t'(reg_wdata);
    cfg_en    = wr_prot && (reg_sel == RSEL_CONFIG);
    bus16_d   = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      timing_q   <= '1;
      bus16_q    <= 1'b0;
    end else begin
      if (lock_en)   unlocked_q <= unlocked_d;
      if (timing_en) timing_q   <= timing_d;
      if (cfg_en)    bus16_q    <= bus16_d;
    end
  end

  assign timing_o   = timing_q;
  assign bus16_o    = bus16_q;
  assign unlocked_o = unlocked_q;

  // R2: a protected write always consumes the armed key
  p_lock_consumed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && unlocked_o && (reg_sel != RSEL_LOCK)) |=> !unlocked_o);

  // R1: while locked, timing writes leave the word untouched
  p_locked_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !unlocked_o && (reg_sel == RSEL_TIMING)) |=> $stable(timing_o));

endmodule

// File: rtl/nand_tg_ready.sv
module nand_tg_ready #(
  parameter int unsigned BUSY_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rb_i,
  input  logic              busy_start,
  input  logic [BUSY_W-1:0] busy_len,
  output logic              ready_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [BUSY_W-1:0]      busy_cnt_q, busy_cnt_d;
  logic                   busy_en;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    logic stage_d;
    if (s == 0) begin : g_first
      assign stage_d = rb_i;
    end else begin : g_next
      assign stage_d = sync_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= 1'b0;
      else        sync_q[s] <= stage_d;
    end
  end

  always_comb begin
    busy_en    = busy_start || (busy_cnt_q != '0);
    busy_cnt_d = busy_start ? busy_len : busy_cnt_q - BUSY_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_cnt_q <= '0;
    else if (busy_en) busy_cnt_q <= busy_cnt_d;
  end

  assign ready_o = (busy_cnt_q == '0) && sync_q[SYNC_STAGES-1];

  // R9: a nonzero busy window starts with ready low
  p_busy_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_start && (busy_len != '0)) |=> !ready_o);

endmodule

// File: rtl/nand_tg_seq.sv
module nand_tg_seq
  import nand_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [1:0]        req_kind_i,
  input  logic [DQ_W-1:0]   req_data_i,
  input  logic              req_busy_i,
  input  logic              req_first_i,
  input  timing_t           timing_i,
  input  logic              bus16_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic              idle_o,
  output logic              done_o,
  output logic [DQ_W-1:0]   rdata_o,
  output logic              ce_n_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_n_o,
  output logic              re_n_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic              busy_start_o,
  output logic [BUSY_W-1:0] busy_len_o
);

  localparam int unsigned HALF_W = DQ_W / 2;

  seq_state_t        state_q, state_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  xfer_kind_t        kind_q, kind_in;
  timing_t           snap_q;
  logic [DQ_W-1:0]   data_q, data_d;
  logic [DQ_W-1:0]   rdata_q, rdata_d;
  logic              busy_q, bus16_q, done_q;
  logic              accept, cnt_zero, finish, capture;
  logic              rd_q, rd_live;
  logic [LEN_W-1:0]  lo_len_q, hi_len_q, lo_len_live;

  always_comb begin
    kind_in     = xfer_kind_t'(req_kind_i);
    rd_q        = (kind_q == XF_RDATA);
    rd_live     = (kind_in == XF_RDATA);
    lo_len_q    = rd_q ? low_len(snap_q.rd_lo) : low_len(snap_q.wr_lo);
    hi_len_q    = rd_q ? high_len(snap_q.rd_hi, snap_q.rd_lo)
                       : high_len(snap_q.wr_hi, snap_q.wr_lo);
    lo_len_live = rd_live ? low_len(timing_i.rd_lo) : low_len(timing_i.wr_lo);
    accept      = req_i && (state_q == ST_IDLE);
    cnt_zero    = (cnt_q == '0);
    data_d      = bus16_i ? req_data_i : {{HALF_W{1'b0}}, req_data_i[HALF_W-1:0]};
    rdata_d     = bus16_q ? dq_i : {{HALF_W{1'b0}}, dq_i[HALF_W-1:0]};
    capture     = (state_q == ST_LOW) && cnt_zero && rd_q;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - LEN_W'(1);
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = cnt_q;
        if (accept) begin
          if (rd_live && req_first_i && (timing_i.cea != '0)) begin
            state_d = ST_CEA;
            cnt_d   = LEN_W'(timing_i.cea) - LEN_W'(1);
          end else begin
            state_d = ST_LOW;
            cnt_d   = lo_len_live - LEN_W'(1);
          end
        end
      end
      ST_CEA: if (cnt_zero) begin
        state_d = ST_LOW;
        cnt_d   = lo_len_q - LEN_W'(1);
      end
      ST_LOW: if (cnt_zero) begin
        state_d = ST_HIGH;
        cnt_d   = hi_len_q - LEN_W'(1);
      end
      ST_HIGH: if (cnt_zero) begin
        if (rd_q && (snap_q.turn != '0)) begin
          state_d = ST_TURN;
          cnt_d   = LEN_W'(snap_q.turn) - LEN_W'(1);
        end else begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end
      end
      ST_TURN: if (cnt_zero) begin
        state_d = ST_IDLE;
        finish  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= XF_CMD;
      snap_q  <= '0;
      data_q  <= '0;
      busy_q  <= 1'b0;
      bus16_q <= 1'b0;
    end else if (accept) begin
      kind_q  <= kind_in;
      snap_q  <= timing_i;
      data_q  <= data_d;
      busy_q  <= req_busy_i;
      bus16_q <= bus16_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= rdata_d;
  end

  assign idle_o       = (state_q == ST_IDLE);
  assign done_o       = done_q;
  assign rdata_o      = rdata_q;
  assign ce_n_o       = (state_q == ST_IDLE);
  assign cle_o        = !idle_o && (kind_q == XF_CMD);
  assign ale_o        = !idle_o && (kind_q == XF_ADDR);
  assign we_n_o       = !((state_q == ST_LOW) && !rd_q);
  assign re_n_o       = !((state_q == ST_LOW) && rd_q);
  assign dq_o         = data_q;
  assign dq_oe_o      = ((state_q == ST_LOW) || (state_q == ST_HIGH)) && !rd_q;
  assign busy_start_o = finish && busy_q;
  assign busy_len_o   = snap_q.busy;

  // Independent run-length counter for the low phase
  logic [LEN_W:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   low_run_q <= '0;
    else if (state_q == ST_LOW)   low_run_q <= low_run_q + 1'b1;
    else                          low_run_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst_n && (state_q == ST_LOW) && (state_d != ST_LOW)) begin
      if (!rd_q) begin
        p_wr_low_len_r3: assert ((low_run_q + 1'b1) == ((LEN_W+1)'(snap_q.wr_lo) + 1'b1))
          else $error("write low phase length mismatch");
      end else begin
        p_rd_low_len_r4: assert ((low_run_q + 1'b1) == ((LEN_W+1)'(snap_q.rd_lo) + 1'b1))
          else $error("read low phase length mismatch");
      end
    end
  end

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_tg_pkg::*;
#(
  parameter logic [15:0] UNLOCK_KEY  = 16'hA25E,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_sel,
  input  logic [TIMING_W-1:0] reg_wdata,
  output logic [TIMING_W-1:0] timing_o,
  output logic                bus16_o,
  output logic                unlocked_o,
  input  logic                req_i,
  input  logic [1:0]          req_kind_i,
  input  logic [DQ_W-1:0]     req_data_i,
  input  logic                req_busy_i,
  input  logic                req_first_i,
  output logic                idle_o,
  output logic                done_o,
  output logic [DQ_W-1:0]     rdata_o,
  output logic                ready_o,
  output logic                nand_ce_n,
  output logic                nand_cle,
  output logic                nand_ale,
  output logic                nand_we_n,
  output logic                nand_re_n,
  output logic [DQ_W-1:0]     nand_dq_o,
  output logic                nand_dq_oe,
  input  logic [DQ_W-1:0]     nand_dq_i,
  input  logic                nand_rb_i
);

  timing_t           timing;
  logic              busy_start;
  logic [BUSY_W-1:0] busy_len;

  nand_tg_regs #(.UNLOCK_KEY(UNLOCK_KEY)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .timing_o   (timing),
    .bus16_o    (bus16_o),
    .unlocked_o (unlocked_o)
  );

  nand_tg_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .req_kind_i   (req_kind_i),
    .req_data_i   (req_data_i),
    .req_busy_i   (req_busy_i),
    .req_first_i  (req_first_i),
    .timing_i     (timing),
    .bus16_i      (bus16_o),
    .dq_i         (nand_dq_i),
    .idle_o       (idle_o),
    .done_o       (done_o),
    .rdata_o      (rdata_o),
    .ce_n_o       (nand_ce_n),
    .cle_o        (nand_cle),
    .ale_o        (nand_ale),
    .we_n_o       (nand_we_n),
    .re_n_o       (nand_re_n),
    .dq_o         (nand_dq_o),
    .dq_oe_o      (nand_dq_oe),
    .busy_start_o (busy_start),
    .busy_len_o   (busy_len)
  );

  nand_tg_ready #(.BUSY_W(BUSY_W), .SYNC_STAGES(SYNC_STAGES)) u_ready (
    .clk        (clk),
    .rst_n      (rst_n),
    .rb_i       (nand_rb_i),
    .busy_start (busy_start),
    .busy_len   (busy_len),
    .ready_o    (ready_o)
  );

  assign timing_o = timing;

  // R7: leaving idle always follows a request
  p_accept_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_o) |-> $past(req_i));

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11: strobes exclusive and enclosed by chip enable
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  p_strobe_ce_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

endmodule

// File: tb/nand_strobe_gen_bench.sv
module nand_strobe_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [25:0] reg_wdata;
  logic [25:0] timing_o;
  logic        bus16_o, unlocked_o;
  logic        req_i;
  logic [1:0]  req_kind_i;
  logic [15:0] req_data_i;
  logic        req_busy_i, req_first_i;
  logic        idle_o, done_o, ready_o;
  logic [15:0] rdata_o;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [15:0] nand_dq_o, nand_dq_i;
  logic        nand_rb_i;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // measurements from the last transfer
  int          m_cea, m_low, m_post;
  logic        m_done, m_cle, m_ale, m_oe, m_idle_bad;
  logic [15:0] m_dq;

  localparam logic [15:0] KEY = 16'hA25E;

  always #2 clk = ~clk;

  nand_strobe_gen u_nand_strobe_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .timing_o(timing_o), .bus16_o(bus16_o),
    .unlocked_o(unlocked_o), .req_i(req_i), .req_kind_i(req_kind_i),
    .req_data_i(req_data_i), .req_busy_i(req_busy_i), .req_first_i(req_first_i),
    .idle_o(idle_o), .done_o(done_o), .rdata_o(rdata_o), .ready_o(ready_o),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb_i(nand_rb_i)
  );

  function automatic logic [25:0] mk_t(int wl, int wh, int rl, int rh,
                                       int ta, int bd, int cea);
    return {cea[1:0], bd[4:0], ta[2:0], rh[3:0], rl[3:0], wh[3:0], wl[3:0]};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [25:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic program_timing(input logic [25:0] val);
    write_reg(2'd0, 26'(KEY));
    write_reg(2'd1, val);
  endtask

  task automatic set_bus16(input logic w);
    write_reg(2'd0, 26'(KEY));
    write_reg(2'd2, 26'(w));
  endtask

  // Issues one request and measures its phases; returns at the first idle sample
  task automatic run_xfer(input logic [1:0] kind, input logic [15:0] data,
                          input logic busy, input logic first);
    bit seen_low = 0;
    int guard = 0;
    m_cea = 0; m_low = 0; m_post = 0;
    m_cle = 0; m_ale = 0; m_oe = 0; m_idle_bad = 0; m_dq = '0;
    @(negedge clk);
    req_i = 1'b1; req_kind_i = kind; req_data_i = data;
    req_busy_i = busy; req_first_i = first;
    @(negedge clk);
    req_i = 1'b0;
    while (nand_ce_n == 1'b0 && guard < 400) begin
      logic strobe;
      strobe = (kind == 2'd3) ? nand_re_n : nand_we_n;
      if (!strobe) begin
        m_low++; seen_low = 1;
      end else if (!seen_low) begin
        m_cea++;
      end else begin
        m_post++;
        if (kind == 2'd3) nand_dq_i = 16'hDEAD;
      end
      if (nand_cle) m_cle = 1;
      if (nand_ale) m_ale = 1;
      if (nand_dq_oe) begin m_oe = 1; m_dq = nand_dq_o; end
      if (idle_o) m_idle_bad = 1;
      @(negedge clk);
      guard++;
    end
    m_done = done_o;
  endtask

  task automatic t_reset;
    chk("R1 reset timing", 32'(timing_o), 32'h3FFFFFF);
    chk("R1 reset bus16", 32'(bus16_o), 0);
    chk("R2 reset locked", 32'(unlocked_o), 0);
    chk("R8 reset idle", 32'(idle_o), 1);
    chk("R8 reset done", 32'(done_o), 0);
    chk("R11 reset strobes", 32'({nand_ce_n, nand_we_n, nand_re_n}), 32'h7);
  endtask

  task automatic t_lock;
    write_reg(2'd1, 26'h0000123);
    chk("R1 locked write ignored", 32'(timing_o), 32'h3FFFFFF);
    write_reg(2'd0, 26'(KEY));
    chk("R1 key arms unlock", 32'(unlocked_o), 1);
    write_reg(2'd1, 26'h0000123);
    chk("R1 unlocked write taken", 32'(timing_o), 32'h123);
    chk("R2 unlock consumed", 32'(unlocked_o), 0);
    write_reg(2'd1, 26'h0000456);
    chk("R2 second write ignored", 32'(timing_o), 32'h123);
    write_reg(2'd0, 26'h000A25F);
    chk("R2 wrong key stays locked", 32'(unlocked_o), 0);
    write_reg(2'd1, 26'h0000789);
    chk("R2 write after wrong key ignored", 32'(timing_o), 32'h123);
    write_reg(2'd0, 26'(KEY));
    write_reg(2'd0, 26'h0001111);
    write_reg(2'd2, 26'h1);
    chk("R2 wrong key revokes unlock", 32'(bus16_o), 0);
  endtask

  task automatic wr_case(input int wl, input int wh, input int el, input int eh);
    program_timing(mk_t(wl, wh, 0, 1, 7, 0, 0));
    run_xfer(2'd2, 16'h0055, 1'b0, 1'b0);
    chk($sformatf("R3 we low wl=%0d wh=%0d", wl, wh), 32'(m_low), 32'(el));
    chk($sformatf("R3 we high wl=%0d wh=%0d (R5 no turnaround)", wl, wh), 32'(m_post), 32'(eh));
    chk("R8 done after write", 32'(m_done), 1);
  endtask

  task automatic t_write_widths;
    wr_case(0, 0, 1, 1);
    wr_case(15, 15, 16, 1);
    wr_case(0, 15, 1, 15);
    wr_case(3, 7, 4, 4);
    wr_case(9, 2, 10, 1);
  endtask

  task automatic rd_case(input int rl, input int rh, input int ta, input int el, input int ep);
    program_timing(mk_t(0, 1, rl, rh, ta, 0, 0));
    nand_dq_i = 16'hA5C3;
    run_xfer(2'd3, 16'h0, 1'b0, 1'b0);
    chk($sformatf("R4 re low rl=%0d", rl), 32'(m_low), 32'(el));
    chk($sformatf("R5 re high+turnaround rh=%0d ta=%0d", rh, ta), 32'(m_post), 32'(ep));
    chk("R4 8-bit capture", 32'(rdata_o), 32'h00C3);
    chk("R11 no drive on read", 32'(m_oe), 0);
  endtask

  task automatic t_read_widths;
    rd_case(0, 0, 0, 1, 1);
    rd_case(15, 15, 7, 16, 8);
    rd_case(2, 9, 0, 3, 7);
    rd_case(0, 15, 1, 1, 16);
    set_bus16(1'b1);
    chk("R1 bus16 set", 32'(bus16_o), 1);
    nand_dq_i = 16'hA5C3;
    run_xfer(2'd3, 16'h0, 1'b0, 1'b0);
    chk("R4 16-bit capture", 32'(rdata_o), 32'hA5C3);
    set_bus16(1'b0);
  endtask

  task automatic t_cea;
    program_timing(mk_t(0, 1, 1, 2, 0, 0, 3));
    run_xfer(2'd3, 16'h0, 1'b0, 1'b1);
    chk("R6 CE access delay cycles", 32'(m_cea), 3);
    chk("R6 low after delay", 32'(m_low), 2);
    run_xfer(2'd3, 16'h0, 1'b0, 1'b0);
    chk("R6 no delay without flag", 32'(m_cea), 0);
    run_xfer(2'd2, 16'h0, 1'b0, 1'b1);
    chk("R6 no delay for write", 32'(m_cea), 0);
    program_timing(mk_t(0, 1, 1, 2, 0, 0, 0));
    run_xfer(2'd3, 16'h0, 1'b0, 1'b1);
    chk("R6 zero delay field", 32'(m_cea), 0);
  endtask

  task automatic t_ignore_req;
    bit re_seen = 0;
    bit ce_seen = 0;
    program_timing(mk_t(6, 12, 0, 1, 0, 0, 0));
    @(negedge clk);
    req_i = 1'b1; req_kind_i = 2'd2; req_data_i = 16'h0011;
    req_busy_i = 1'b0; req_first_i = 1'b0;
    @(negedge clk);
    req_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 busy while transferring", 32'(idle_o), 0);
    req_i = 1'b1; req_kind_i = 2'd3;
    @(negedge clk);
    req_i = 1'b0;
    while (nand_ce_n == 1'b0) begin
      if (!nand_re_n) re_seen = 1;
      @(negedge clk);
    end
    chk("R8 done at first idle sample", 32'(done_o), 1);
    @(negedge clk);
    chk("R8 done lasts one cycle", 32'(done_o), 0);
    repeat (3) begin
      if (!nand_ce_n) ce_seen = 1;
      @(negedge clk);
    end
    chk("R7 dropped request never strobed", 32'(re_seen), 0);
    chk("R7 dropped request started nothing", 32'(ce_seen), 0);
  endtask

  task automatic busy_case(input int bd, input logic busy, input int expct);
    int cnt = 0;
    program_timing(mk_t(0, 1, 0, 1, 0, bd, 0));
    run_xfer(2'd0, 16'h0060, busy, 1'b0);
    while (!ready_o && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk($sformatf("R9 ready low cycles bd=%0d busy=%0d", bd, busy), 32'(cnt), 32'(expct));
  endtask

  task automatic t_busy;
    busy_case(5, 1'b1, 5);
    busy_case(31, 1'b1, 31);
    busy_case(0, 1'b1, 0);
    busy_case(5, 1'b0, 0);
  endtask

  task automatic t_sync;
    repeat (4) @(negedge clk);
    nand_rb_i = 1'b0;
    @(negedge clk);
    chk("R10 one edge: still ready", 32'(ready_o), 1);
    @(negedge clk);
    chk("R10 two edges: busy seen", 32'(ready_o), 0);
    nand_rb_i = 1'b1;
    @(negedge clk);
    chk("R10 one edge: still busy", 32'(ready_o), 0);
    @(negedge clk);
    chk("R10 two edges: ready seen", 32'(ready_o), 1);
  endtask

  task automatic t_signals;
    program_timing(mk_t(1, 3, 1, 3, 0, 0, 0));
    run_xfer(2'd0, 16'hBE90, 1'b0, 1'b0);
    chk("R11 CLE on command", 32'(m_cle), 1);
    chk("R11 no ALE on command", 32'(m_ale), 0);
    chk("R11 command drives bus 8-bit", 32'(m_dq), 32'h0090);
    chk("R7 not idle during transfer", 32'(m_idle_bad), 0);
    run_xfer(2'd1, 16'h0012, 1'b0, 1'b0);
    chk("R11 ALE on address", 32'(m_ale), 1);
    chk("R11 no CLE on address", 32'(m_cle), 0);
    chk("R11 address drives bus", 32'(m_oe), 1);
    set_bus16(1'b1);
    run_xfer(2'd2, 16'hBEEF, 1'b0, 1'b0);
    chk("R11 16-bit write data", 32'(m_dq), 32'hBEEF);
    chk("R11 no latches on data", 32'({m_cle, m_ale}), 0);
    set_bus16(1'b0);
  endtask

  task automatic t_snapshot;
    program_timing(mk_t(9, 10, 0, 1, 0, 0, 0));
    fork
      run_xfer(2'd2, 16'h0001, 1'b0, 1'b0);
      begin
        repeat (2) @(negedge clk);
        program_timing(mk_t(0, 1, 0, 1, 0, 0, 0));
      end
    join
    chk("R12 in-flight transfer keeps old low", 32'(m_low), 10);
    chk("R12 new timing visible", 32'(timing_o), 32'(mk_t(0, 1, 0, 1, 0, 0, 0)));
    run_xfer(2'd2, 16'h0001, 1'b0, 1'b0);
    chk("R12 next transfer uses new low", 32'(m_low), 1);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
    req_i = 1'b0; req_kind_i = '0; req_data_i = '0;
    req_busy_i = 1'b0; req_first_i = 1'b0;
    nand_dq_i = '0; nand_rb_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_write_widths();
    t_read_widths();
    t_cea();
    t_ignore_req();
    t_busy();
    t_sync();
    t_signals();
    t_snapshot();
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule